// File: doc/BRIEF.md
# Programmable Interrupt Trigger Conditioner

This block sits between a bank of raw interrupt lines and the mask stages that forward requests to a processor. Each line first passes through a synchroniser. It is then turned into one conditioned request in one of four ways: it can latch a rising edge, latch a falling edge, pass a high level, or pass an inverted low level. The conditioned vector goes out as several identical copies, one for each downstream mask stage.

Software reaches the block through a simple word-addressed register port. The lines are grouped into 32-bit halves. Each half has eight word slots:

| Word | Meaning |
|---|---|
| 0 | synchronised line state |
| 1 | conditioned state; writing ones here acknowledges latched edges |
| 2 | rise vector, read-only |
| 3 | fall vector, read-only |
| 4 | rise set alias |
| 5 | rise clear alias |
| 6 | fall set alias |
| 7 | fall clear alias |

Address bit 3 selects the high half. The high half therefore sits 0x20 bytes, or 8 words, above the low half. The alias slots read as zero.

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset, the rise and fall vectors are zero in both halves and no edge is latched, so every line behaves as an active-high level.
- R2: With rise=0 and fall=0, a line's conditioned output equals its input as it was two clock edges earlier, through a two-flop synchroniser.
- R3: With rise=1 and fall=1, the conditioned output is the inverse of the synchronised input.
- R4: With rise=1 and fall=0, a 0-to-1 change between successive synchronised samples latches the line's bit. The bit stays 1 until it is acknowledged. A one-cycle input pulse is enough to latch it.
- R5: With rise=0 and fall=1, only a 1-to-0 change latches the line. A rising change is ignored.
- R6: A write to a set alias (word 4 for rise, 6 for fall) sets exactly the bits written as 1. A write to a clear alias (word 5 for rise, 7 for fall) clears exactly those bits. Bits written as 0 leave the vector unchanged.
- R7: A write of 1 to a bit of word 1 clears that latched edge, and 0 bits leave other latched edges alone. Writing all ones clears every latched edge in that half only.
- R8: If an edge is detected on a line in the same cycle as its acknowledge is written, the edge wins and the bit stays set.
- R9: In either level mode, acknowledge writes have no effect on the output.
- R10: The high half (lines 32 to 63) uses word addresses 8 to 15, with the same slot meanings as words 0 to 7.
- R11: All sink copies of the conditioned vector are identical in every cycle.
- R12: Word 0 of a half reads the synchronised input lines of that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Raw interrupt lines, may be asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Word address: bits [2:0] select the slot, the upper bits select the half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cond_out | output | N_SINKS*N_LINES | Conditioned requests, one N_LINES copy for each sink |

## Verification
The hardest case to reach is an acknowledge that lands in the exact cycle in which a new edge on the same, already latched line is being detected. The input pass through three registers before detection can occur. To reach this case, the stimulus raises the line, waits two clocks, and then issues the acknowledge write so that it is registered on the same edge as the new latch. A later plain acknowledge shows that the bit was held by the edge and not by a lost write. A free-running phase of pseudo-random line toggles and register writes is then compared every clock against a behavioural model.

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond #(
  parameter int N_LINES = 64,
  parameter int N_SINKS = 3,
  localparam int WORD   = 32,
  localparam int N_HALF = N_LINES / WORD,
  localparam int AW     = $clog2(N_HALF) + 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         irq_in,
  input  logic                       bus_we,
  input  logic [AW-1:0]              bus_addr,
  input  logic [WORD-1:0]            bus_wdata,
  output logic [WORD-1:0]            bus_rdata,
  output logic [N_SINKS*N_LINES-1:0] cond_out
);
  logic [N_LINES-1:0] meta_q, sync_q, last_q, rise_q, fall_q, lat_q;
  logic [N_LINES-1:0] wr_v, ack_v, hit_v, edge_v, cond_v;
  logic [2:0]    reg_sel;
  logic [AW-4:0] half_sel;

  assign reg_sel  = bus_addr[2:0];
  assign half_sel = bus_addr[AW-1:3];

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign wr_v[h*WORD +: WORD] = (bus_we && half_sel == (AW-3)'(h)) ? bus_wdata : '0;
  end

  assign ack_v  = (reg_sel == 3'd1) ? wr_v : '0;
  assign edge_v = rise_q ^ fall_q;
  assign hit_v  = edge_v & ((rise_q & sync_q & ~last_q) | (fall_q & ~sync_q & last_q));
  assign cond_v = (edge_v & lat_q) | (~edge_v & (sync_q ^ rise_q));

  for (genvar k = 0; k < N_SINKS; k++) begin : g_sink
    assign cond_out[k*N_LINES +: N_LINES] = cond_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
      lat_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      meta_q <= irq_in;
      sync_q <= meta_q;
      last_q <= sync_q;
      lat_q  <= edge_v & (hit_v | (lat_q & ~ack_v));
      case (reg_sel)
        3'd4:    rise_q <= rise_q | wr_v;
        3'd5:    rise_q <= rise_q & ~wr_v;
        3'd6:    fall_q <= fall_q | wr_v;
        3'd7:    fall_q <= fall_q & ~wr_v;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < N_HALF; h++) begin
      if (half_sel == (AW-3)'(h)) begin
        case (reg_sel)
          3'd0:    bus_rdata = sync_q[h*WORD +: WORD];
          3'd1:    bus_rdata = cond_v[h*WORD +: WORD];
          3'd2:    bus_rdata = rise_q[h*WORD +: WORD];
          3'd3:    bus_rdata = fall_q[h*WORD +: WORD];
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

module irq_trigger_cond_chk #(
  parameter int N_LINES = 64,
  parameter int AW      = 4,
  localparam int WORD   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_in,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [WORD-1:0]    bus_wdata,
  input logic [N_LINES-1:0] cond_lo,
  input logic [N_LINES-1:0] rise_cfg,
  input logic [N_LINES-1:0] fall_cfg,
  input logic [N_LINES-1:0] edge_lat,
  input logic [N_LINES-1:0] ack_vec,
  input logic [N_LINES-1:0] edge_hit
);
  logic [1:0]         up_cnt;
  logic [N_LINES-1:0] wmask, lvl_hi, emode;

  assign wmask  = {{(N_LINES-WORD){1'b0}}, bus_wdata} << (WORD * int'(bus_addr[AW-1:3]));
  assign lvl_hi = ~rise_cfg & ~fall_cfg;
  assign emode  = rise_cfg ^ fall_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (rise_cfg == '0 && fall_cfg == '0 && edge_lat == '0));

  p_level_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (((cond_lo ^ $past(irq_in, 2)) & lvl_hi) == '0));

  p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_lat) & ~$past(ack_vec) & $past(emode) & ~edge_lat) == '0));

  p_latch_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_lat & ~$past(edge_lat) & ~$past(edge_hit)) == '0));

  p_edge_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_hit) & ~edge_lat) == '0));

  p_rise_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[2:0] == 3'd4) |=> (rise_cfg == ($past(rise_cfg) | $past(wmask))));

  p_fall_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[2:0] == 3'd7) |=> (fall_cfg == ($past(fall_cfg) & ~$past(wmask))));
endmodule

bind irq_trigger_cond irq_trigger_cond_chk #(.N_LINES(N_LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cond_lo(cond_out[N_LINES-1:0]), .rise_cfg(rise_q),
  .fall_cfg(fall_q), .edge_lat(lat_q), .ack_vec(ack_v), .edge_hit(hit_v)
);

// File: tb/irq_trigger_cond_test.sv
module irq_trigger_cond_test;
  localparam int N = 64;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]   irq_in = '0;
  logic           bus_we = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [S*N-1:0] cond_out;

  irq_trigger_cond #(.N_LINES(N), .N_SINKS(S)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cond_out(cond_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] hist[$];
  logic [N-1:0] m_rise = '0, m_fall = '0, m_lat = '0;

  function automatic logic [N-1:0] m_sync();
    return hist[hist.size()-2];
  endfunction

  function automatic logic [N-1:0] m_prev();
    return hist[hist.size()-3];
  endfunction

  function automatic logic [N-1:0] m_cond();
    logic [N-1:0] r, s;
    s = m_sync();
    for (int i = 0; i < N; i++)
      r[i] = (m_rise[i] != m_fall[i]) ? m_lat[i] : (s[i] ^ m_rise[i]);
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    int b;
    logic [N-1:0] v;
    b = a[3] ? 32 : 0;
    case (a[2:0])
      3'd0:    v = m_sync();
      3'd1:    v = m_cond();
      3'd2:    v = m_rise;
      3'd3:    v = m_fall;
      default: v = '0;
    endcase
    return v[b +: 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{64'd0, 64'd0, 64'd0};
      m_rise = '0; m_fall = '0; m_lat = '0;
    end else begin
      logic [N-1:0] w, s, p;
      w = bus_we ? ({32'd0, bus_wdata} << (bus_addr[3] ? 32 : 0)) : '0;
      s = m_sync();
      p = m_prev();
      for (int i = 0; i < N; i++) begin
        if (m_rise[i] != m_fall[i]) begin
          bit hit;
          hit = m_rise[i] ? (s[i] && !p[i]) : (!s[i] && p[i]);
          m_lat[i] = hit || (m_lat[i] && !(bus_addr[2:0] == 3'd1 && w[i]));
        end else begin
          m_lat[i] = 1'b0;
        end
      end
      case (bus_addr[2:0])
        3'd4: m_rise = m_rise | w;
        3'd5: m_rise = m_rise & ~w;
        3'd6: m_fall = m_fall | w;
        3'd7: m_fall = m_fall & ~w;
        default: ;
      endcase
      hist.push_back(irq_in);
      void'(hist.pop_front());
    end
  end

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 1; k < S; k++)
        check(cond_out[k*N +: N] === cond_out[N-1:0], "R11 sink copy", cond_out[k*N +: N], cond_out[N-1:0]);
      check(cond_out[N-1:0] === m_cond(), "R2 R3 R4 R5 R8 R9 conditioned vs model", cond_out[N-1:0], m_cond());
      check(bus_rdata === m_read(bus_addr), "R6 R7 R10 R12 read vs model", 64'(bus_rdata), 64'(m_read(bus_addr)));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    @(negedge clk);
    check(bus_rdata === exp, tag, 64'(bus_rdata), 64'(exp));
    step();
  endtask

  task automatic bit_chk(int idx, logic exp, string tag);
    @(negedge clk);
    check(cond_out[idx] === exp, tag, 64'(cond_out[idx]), 64'(exp));
    step();
  endtask

  task automatic pulse(int idx);
    irq_in[idx] = 1'b1; step();
    irq_in[idx] = 1'b0; step(); step(); step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    hist = '{64'd0, 64'd0, 64'd0};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd_chk(4'd2, 32'd0, "R1 rise low");
    rd_chk(4'd11, 32'd0, "R1 fall high");
    rd_chk(4'd1, 32'd0, "R1 raw low");
    @(negedge clk);
    check(cond_out === '0, "R1 outputs idle", cond_out[N-1:0], '0);
    step();

    // R2 two-stage latency
    irq_in[3] = 1'b1;
    bit_chk(3, 1'b0, "R2 before sample");
    bit_chk(3, 1'b0, "R2 one stage");
    bit_chk(3, 1'b1, "R2 two stages");
    rd_chk(4'd0, 32'h8, "R12 line status");

    // R3 active-low level
    wr(4'd4, 32'h20);
    wr(4'd6, 32'h20);
    bit_chk(5, 1'b1, "R3 low input asserts");
    irq_in[5] = 1'b1;
    step(); step();
    bit_chk(5, 1'b0, "R3 high input deasserts");

    // R6 set/clear aliases
    wr(4'd4, 32'h0F00);
    rd_chk(4'd2, 32'h0F20, "R6 rise set");
    wr(4'd5, 32'h0300);
    rd_chk(4'd2, 32'h0C20, "R6 rise clear");
    rd_chk(4'd3, 32'h20, "R6 fall untouched");

    // R4 rising edge latch
    pulse(10);
    bit_chk(10, 1'b1, "R4 pulse latched");
    rd_chk(4'd1, 32'h408, "R4 raw word");

    // R7 acknowledge
    wr(4'd1, 32'h800);
    bit_chk(10, 1'b1, "R7 zero bits ignored");
    wr(4'd1, 32'h400);
    bit_chk(10, 1'b0, "R7 ack clears");

    // R5 falling edge, R10 high half
    wr(4'd14, 32'h100);
    rd_chk(4'd11, 32'h100, "R10 high fall vector");
    irq_in[40] = 1'b1;
    step(); step(); step();
    bit_chk(40, 1'b0, "R5 rising ignored");
    irq_in[40] = 1'b0;
    step(); step(); step();
    bit_chk(40, 1'b1, "R5 falling latched");
    rd_chk(4'd9, 32'h100, "R10 high raw word");

    // R7 all ones per half
    pulse(10);
    wr(4'd9, 32'hFFFF_FFFF);
    bit_chk(40, 1'b0, "R7 all ones high half");
    bit_chk(10, 1'b1, "R7 other half kept");
    wr(4'd1, 32'hFFFF_FFFF);
    bit_chk(10, 1'b0, "R7 all ones low half");
    bit_chk(3, 1'b1, "R9 level ignores ack");
    bit_chk(5, 1'b0, "R9 low level ignores ack");

    // R8 edge and ack in the same cycle
    pulse(10);
    irq_in[10] = 1'b1;
    step(); step();
    wr(4'd1, 32'h400);
    bit_chk(10, 1'b1, "R8 new edge wins");
    wr(4'd1, 32'h400);
    bit_chk(10, 1'b0, "R8 later ack clears");

    // R11 copies
    @(negedge clk);
    check(cond_out[N +: N] === cond_out[N-1:0] && cond_out[2*N +: N] === cond_out[N-1:0],
          "R11 copies equal", cond_out[N +: N], cond_out[N-1:0]);
    step();

    // mixed traffic against the model
    for (int c = 0; c < 400; c++) begin
      irq_in = {$urandom, $urandom};
      bus_addr = 4'($urandom);
      bus_wdata = $urandom;
      bus_we = ($urandom % 4) == 0;
      step();
    end
    bus_we = 1'b0;
    step(); step();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule